// File: doc/BRIEF.md
# Run-Skipping Shift-Add Multiplier with Completion-Timed Adder

This block multiplies two unsigned N-bit operands into a 2N-bit product. It walks the multiplier operand from its least significant bit, one position per step. Inside a run of equal bits it only shifts. At each boundary between runs it does one arithmetic operation. The multiplicand is subtracted where a run of ones begins and added back where that run ends. A zero is implied above the operand's top bit, so a run of ones that reaches the top still closes with an add.

Each add or subtract goes to a separate adder that reports when its carries have settled. The next step waits for that report instead of a fixed worst-case period. One clock cycle models one delay unit.

The block also reports how many delay units the whole operation took. This allows the mean cost over many operand pairs to be compared against a fixed-period shift-add design.

Top module: `rsm_mul`

## Requirements
- R1: While reset is held, and after it is released, `busy` and `done` are 0 and `product` and `units` are 0.
- R2: When `done` is high, `product` equals the unsigned product of the `mcand` and `mplier` values that were sampled when the start was accepted. This holds for every operand value, including zero and all ones.
- R3: The step at multiplier position i looks at the pair (bit i, bit i-1). Bit -1 is 0, and bit N is an implied 0. There are N+1 steps in total. A pair whose two bits are equal costs exactly one delay unit and does no arithmetic. A zero multiplier therefore takes exactly N+1 units.
- R4: A pair (1,0) subtracts the multiplicand from the upper accumulator. A pair (0,1) adds it. A multiplier with its top bit set therefore ends with a final add.
- R5: Each arithmetic step costs 4 + L delay units: one unit for operand selection, 1 + L units inside the adder, one unit for the completion trigger and one unit for the shift. L is the longest run of consecutive 1s in `acc ^ opnd`. Here `acc` is the (N+1)-bit upper accumulator and `opnd` is the zero-extended multiplicand, or its bitwise complement when subtracting.
- R6: `units` counts one per busy cycle, starting from 0 when a start is accepted. After `done`, both `units` and `product` hold until the next accepted start.
- R7: A start that is sampled while idle makes `busy` high on the next cycle. `done` is a single-cycle pulse and arrives exactly `units` cycles after the accepting edge.
- R8: A `start` asserted while `busy` is high is ignored, together with the operands present at that time. The result and cost are those of the running operation, and no second operation follows.
- R9: With N = 12, multiplicand 0x4B7 and multiplier 0x6C0 give product 0x1FD340. The unit count equals the sum of the step costs given by R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one delay unit |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin; only sampled while idle |
| mcand | input | N | Multiplicand |
| mplier | input | N | Multiplier operand that is scanned for runs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2N | Unsigned product, held until the next start |
| units | output | $clog2((N+1)(N+6)+1) | Delay units used by the last or current operation |

## Verification
The hardest case to reach is an arithmetic step in which the accumulator and the selected operand differ along a long stretch of bits, so that the adder's completion time approaches its worst case. This case also has to occur in the middle of an intermediate negative accumulator. Directed operands reach it: all-ones multiplicands, alternating-bit multipliers, and multipliers whose top bit is set, which force the closing add. Many random pairs then spread the carry-run lengths. For every operation, a bench-side step model predicts the exact unit count and the cycle on which `done` should appear.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WAIT,
        ST_TRIG,
        ST_SHIFT
    } rsm_state_e;

    typedef enum logic [1:0] {
        OP_SKIP,
        OP_ADD,
        OP_SUB
    } rsm_op_e;

    // Upper bound on units: N+1 steps, each at most 4 + (N+1) units.
    function automatic int units_width(input int n);
        return $clog2((n + 1) * (n + 6) + 1);
    endfunction

endpackage

// File: rtl/rsm_recode.sv
module rsm_recode
    import rsm_pkg::*;
(
    input  logic    cur_bit,
    input  logic    prev_bit,
    output rsm_op_e op
);
    // A run of ones starts at (1,0) and ends at (0,1).
    always_comb begin
        case ({cur_bit, prev_bit})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_SKIP;
        endcase
    end
endmodule

// File: rtl/rsm_cca.sv
module rsm_cca #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic         fin,
    output logic [W-1:0] sum
);
    logic [W-1:0] a_q, b_q, res_q, res_nxt, prop;
    logic         cin_q, base_q, run_q;

    // A non-propagating position settles in the first unit.
    // A propagating position settles one unit after its lower neighbour.
    assign prop    = a_q ^ b_q;
    assign res_nxt = ~prop | {res_q[W-2:0], base_q};
    assign fin     = run_q && (&res_nxt);
    assign sum     = a_q + b_q + W'(cin_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            cin_q  <= 1'b0;
            res_q  <= '0;
            base_q <= 1'b0;
            run_q  <= 1'b0;
        end else if (go) begin
            a_q    <= a;
            b_q    <= b;
            cin_q  <= cin;
            res_q  <= '0;
            base_q <= 1'b0;
            run_q  <= 1'b1;
        end else if (run_q) begin
            if (fin) begin
                run_q <= 1'b0;
            end else begin
                res_q  <= res_nxt;
                base_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsm_mul.sv
module rsm_mul
    import rsm_pkg::*;
#(
    parameter int N = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [N-1:0]                  mcand,
    input  logic [N-1:0]                  mplier,
    output logic                          busy,
    output logic                          done,
    output logic [2*N-1:0]                product,
    output logic [units_width(N)-1:0]     units
);
    localparam int AW = N + 1;
    localparam int CW = units_width(N);
    localparam int SW = $clog2(AW + 1);

    rsm_state_e       state_q;
    logic [AW-1:0]    hi_q, lo_q;
    logic             qprev_q;
    logic [N-1:0]     mc_q;
    logic [SW-1:0]    step_q;
    logic [CW-1:0]    units_q;
    logic             done_q;
    logic [2*N-1:0]   prod_q;

    rsm_op_e          op_now;
    logic [AW-1:0]    addend, hi_sh, lo_sh, cca_sum;
    logic             cca_go, cca_fin, shift_en, last_step;

    rsm_recode u_rec (
        .cur_bit  (lo_q[0]),
        .prev_bit (qprev_q),
        .op       (op_now)
    );

    assign addend = (op_now == OP_SUB) ? ~{1'b0, mc_q} : {1'b0, mc_q};
    assign cca_go = (state_q == ST_SCAN) && (op_now != OP_SKIP);

    rsm_cca #(.W(AW)) u_cca (
        .clk (clk),
        .rst (rst),
        .go  (cca_go),
        .a   (hi_q),
        .b   (addend),
        .cin (op_now == OP_SUB),
        .fin (cca_fin),
        .sum (cca_sum)
    );

    // Arithmetic right shift across {hi, lo, qprev}.
    assign hi_sh     = {hi_q[AW-1], hi_q[AW-1:1]};
    assign lo_sh     = {hi_q[0], lo_q[AW-1:1]};
    assign shift_en  = ((state_q == ST_SCAN) && (op_now == OP_SKIP)) ||
                       (state_q == ST_SHIFT);
    assign last_step = (step_q == SW'(AW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hi_q    <= '0;
            lo_q    <= '0;
            qprev_q <= 1'b0;
            mc_q    <= '0;
            step_q  <= '0;
            units_q <= '0;
            done_q  <= 1'b0;
            prod_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q != ST_IDLE) begin
                units_q <= units_q + 1'b1;
            end
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        hi_q    <= '0;
                        lo_q    <= {1'b0, mplier};
                        qprev_q <= 1'b0;
                        mc_q    <= mcand;
                        step_q  <= '0;
                        units_q <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (op_now != OP_SKIP) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cca_fin) begin
                        hi_q    <= cca_sum;
                        state_q <= ST_TRIG;
                    end
                end
                ST_TRIG:  state_q <= ST_SHIFT;
                default: ;
            endcase
            if (shift_en) begin
                hi_q    <= hi_sh;
                lo_q    <= lo_sh;
                qprev_q <= lo_q[0];
                step_q  <= step_q + 1'b1;
                if (last_step) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    prod_q  <= {hi_sh[N-2:0], lo_sh};
                end else begin
                    state_q <= ST_SCAN;
                end
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign product = prod_q;
    assign units   = units_q;

endmodule

// File: rtl/rsm_mul_chk.sv
module rsm_mul_chk #(
    parameter int N  = 12,
    parameter int CW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product,
    input logic [CW-1:0]  units
);
    logic [2*N-1:0] exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
        end else if (start && !busy) begin
            exp_q <= {{N{1'b0}}, mcand} * {{N{1'b0}}, mplier};
        end
    end

    a_r2_product_ok: assert property (@(posedge clk) disable iff (rst)
        done |-> product == exp_q);

    a_r7_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_units_step: assert property (@(posedge clk) disable iff (rst)
        busy |=> units == CW'($past(units) + 1'b1));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(units) && $stable(product)));

    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind rsm_mul rsm_mul_chk #(.N(N), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .busy    (busy),
    .done    (done),
    .product (product),
    .units   (units)
);

// File: tb/rsm_mul_bench.sv
`timescale 1ns/1ps
module rsm_mul_bench;
    localparam int N  = 12;
    localparam int AW = N + 1;
    localparam int CW = $clog2((N + 1) * (N + 6) + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           busy, done;
    logic [2*N-1:0] product;
    logic [CW-1:0]  units;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    logic [2*N-1:0] q_prod[$];
    int             q_units[$];
    int             q_t0[$];
    string          q_tag[$];
    logic [2*N-1:0] last_prod = '0;
    int             last_units = 0;
    logic           prev_done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rsm_mul #(.N(N)) u_rsm_mul (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product), .units(units)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Step cost model taken from R3 and R5.
    function automatic int model_units(input logic [N-1:0] mc, input logic [N-1:0] mp);
        logic [AW-1:0] hi, lo, b, p;
        logic qp;
        int u, run, best;
        hi = '0; lo = {1'b0, mp}; qp = 1'b0; u = 0;
        for (int i = 0; i < AW; i++) begin
            if (lo[0] == qp) begin
                u += 1;
            end else begin
                b = lo[0] ? ~{1'b0, mc} : {1'b0, mc};
                p = hi ^ b;
                run = 0; best = 0;
                for (int j = 0; j < AW; j++) begin
                    if (p[j]) begin run++; if (run > best) best = run; end
                    else run = 0;
                end
                u += 4 + best;
                hi = hi + b + AW'(lo[0]);
            end
            qp = lo[0];
            lo = {hi[0], lo[AW-1:1]};
            hi = {hi[AW-1], hi[AW-1:1]};
        end
        return u;
    endfunction

    // Driver: pushes expected items and issues the start.
    task automatic run_op(input logic [N-1:0] mc, input logic [N-1:0] mp, input string tag);
        while (busy) @(negedge clk);
        mcand = mc; mplier = mp; start = 1'b1;
        q_prod.push_back({{N{1'b0}}, mc} * {{N{1'b0}}, mp});
        q_units.push_back(model_units(mc, mp));
        q_t0.push_back(cyc);
        q_tag.push_back(tag);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (q_prod.size() != 0 || busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops and compares at each done.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (done && prev_done) check(1'b0, "R7 done longer than one cycle", 1, 0);
                if (done) begin
                    if (q_prod.size() == 0) begin
                        check(1'b0, "R8 unexpected done", 1, 0);
                    end else begin
                        logic [2*N-1:0] ep;
                        int eu, t0;
                        string tg;
                        ep = q_prod.pop_front(); eu = q_units.pop_front();
                        t0 = q_t0.pop_front();   tg = q_tag.pop_front();
                        check(product == ep, {"R2 product ", tg}, product, ep);
                        check(int'(units) == eu, {"R5 units ", tg}, units, eu);
                        check(cyc - t0 - 1 == eu, {"R7 done latency ", tg}, cyc - t0 - 1, eu);
                        last_prod = ep; last_units = eu;
                    end
                end
                prev_done = done;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(product == '0, "R1 product after reset", product, 0);
        check(units == '0, "R1 units after reset", units, 0);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);

        // R9 worked case
        run_op(12'h4B7, 12'h6C0, "R9");
        drain();
        check(product == 24'h1FD340, "R9 fixed product", product, 24'h1FD340);

        // R3 zero multiplier: shift only
        run_op(12'h5A5, 12'h000, "R3");
        drain();
        check(int'(units) == N + 1, "R3 zero multiplier units", units, N + 1);

        // R4 top bit set forces the closing add; boundaries of R2
        run_op(12'hFFF, 12'hFFF, "R4 all ones");
        run_op(12'h001, 12'h800, "R4 top bit");
        run_op(12'hFFF, 12'h555, "R4 alternating");
        run_op(12'h000, 12'hAAA, "R2 zero mcand");
        run_op(12'hABC, 12'h001, "R2 one");
        run_op(12'h800, 12'hF0F, "R5 long carry");
        drain();

        // R6 hold after done
        repeat (10) @(negedge clk);
        check(int'(units) == last_units, "R6 units hold", units, last_units);
        check(product == last_prod, "R6 product hold", product, last_prod);

        // R8 start while busy is ignored
        run_op(12'h123, 12'h456, "R8 first op");
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R7 busy during run", busy, 1);
        mcand = 12'hFFF; mplier = 12'hFFF; start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        drain();
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R8 no second run", busy, 0);
        check(product == 24'(12'h123 * 24'h456), "R8 product kept", product, 24'(12'h123 * 24'h456));

        // Random pairs for R2/R5
        for (int k = 0; k < 40; k++) begin
            run_op(N'($urandom), N'($urandom), "R5 random");
        end
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule